// File: doc/BRIEF.md
# Encoded Priority Interrupt Level Decoder

This block receives a four-bit encoded interrupt level from external pins and turns it into one of fifteen individual interrupt sources. Level 0 means that no request is present. Level 1 is the lowest priority and level 15 the highest. The source index is the level with all four bits inverted, so level 15 selects source 0 and level 1 selects source 14. At most one source of the bundle is pending at any time. Each source has a fixed exception vector code, starting at 0x200 and spaced 0x20 apart.

The pins are asynchronous. They pass through a two-flop synchronizer and then a stability filter, which accepts a new value only after it has been seen unchanged on two consecutive clock cycles. A registered group enable gates the whole bundle.

The CPU side has four signals: a request, an acknowledge, the vector code and the priority. A small state machine drives the request:
- **ST_IDLE**: no request. It moves to ST_REQ when the group is enabled and the accepted level is nonzero.
- **ST_REQ**: request raised. It moves to ST_SERVED on acknowledge, to ST_SWITCH when the accepted level changes to another nonzero value, and back to ST_IDLE when the level is 0 or the group is disabled.
- **ST_SERVED**: request still raised after acknowledge, because the source is level sensitive. It has the same exits as ST_REQ, except the one taken on acknowledge.
- **ST_SWITCH**: a one-cycle gap that clears the old source. It then loads the new level and goes to ST_REQ, or goes to ST_IDLE if the level is no longer valid.

Top module: `irl_level_decoder`

## Requirements
- R1: After reset, irq_req is 0 and src_pending, irq_vec and irq_prio are all zero; the enable register and the synchronizer hold 0.
- R2: With the group enabled and a stable nonzero level L on irl_in, irq_req is 1 and irq_prio equals L. Exactly bit (L XOR 15) of src_pending is set: L=15 sets bit 0 and L=1 sets bit 14.
- R3: While irq_req is 1, irq_vec equals 0x200 + 0x20 × (L XOR 15), which ranges from 0x200 for source 0 to 0x3C0 for source 14. While irq_req is 0, irq_vec and irq_prio read 0.
- R4: A stable level 0 clears every bit of src_pending and drops irq_req.
- R5: src_pending never has more than one bit set. A change from one nonzero level to another drops irq_req and src_pending for exactly one cycle (ST_SWITCH), then raises them for the new source only.
- R6: A value on irl_in is accepted only after it has been stable for two consecutive synchronized samples. A value present for one clock cycle has no effect on the outputs. A value held for two cycles is accepted.
- R7: irq_req rises on the fifth rising edge after irl_in changes from 0 to a nonzero level, and is still 0 after the fourth.
- R8: When grp_en is 0 at a rising edge, all outputs read zero after that edge. The accepted level is still tracked while the group is disabled. When grp_en returns to 1 with a nonzero level present, irq_req rises after the second edge.
- R9: irq_ack does not clear the pending source. irq_req, irq_prio and src_pending keep their values after acknowledge until the level changes.
- R10: While irq_req stays 1 from one cycle to the next, irq_vec and irq_prio do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irl_in | input | 4 | Encoded interrupt level from the pins (asynchronous) |
| grp_en | input | 1 | Group enable for the whole fifteen-source bundle |
| irq_ack | input | 1 | CPU acknowledge of the request |
| src_pending | output | 15 | One-hot pending vector, bit n = source n |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 12 | Exception vector code of the pending source |
| irq_prio | output | 4 | Priority level of the pending source |

## Verification
The path from the pins to the request has five registers: two synchronizer flops, the filter's previous-sample register, the accepted-level register and the state register. A level change driven on a falling edge therefore appears on irq_req after the fifth rising edge. A change from one nonzero level to another gives a zero gap after the fifth edge and the new source after the sixth. The bench drives stimulus only on falling edges and samples on a later falling edge after an exact count of rising edges. It also samples one edge early to show the output has not yet moved. grp_en is registered once, so a disable is visible after one edge and a re-enable after two; the sweeps over every level and every ordered pair of levels keep to these counts.

// File: rtl/irl_pkg.sv
package irl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_SERVED = 2'd2,
        ST_SWITCH = 2'd3
    } irl_state_e;

endpackage

// File: rtl/irl_sync_filter.sv
module irl_sync_filter #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] pin_lvl,
    output logic [LVL_W-1:0] lvl_q
);

    logic [LVL_W-1:0] meta_q;
    logic [LVL_W-1:0] sync_q;
    logic [LVL_W-1:0] prev_q;
    logic             steady;

    // two samples in a row agree
    assign steady = (sync_q == prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
            lvl_q  <= '0;
        end else begin
            meta_q <= pin_lvl;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (steady) begin
                lvl_q <= sync_q;
            end
        end
    end

endmodule

// File: rtl/irl_source_decode.sv
module irl_source_decode #(
    parameter int                 LVL_W    = 4,
    parameter int                 VEC_W    = 12,
    parameter logic [VEC_W-1:0]   VEC_BASE = 12'h200,
    parameter logic [VEC_W-1:0]   VEC_STEP = 12'h020,
    localparam int                NUM_SRC  = (1 << LVL_W) - 1
) (
    input  logic               valid,
    input  logic [LVL_W-1:0]   act_lvl,
    output logic [NUM_SRC-1:0] pending,
    output logic [VEC_W-1:0]   vec_code,
    output logic [LVL_W-1:0]   prio
);

    logic [LVL_W-1:0] src_idx;

    // highest level maps to source 0
    assign src_idx = act_lvl ^ {LVL_W{1'b1}};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign pending[g] = valid && (src_idx == LVL_W'(g));
    end

    always_comb begin
        if (valid) begin
            vec_code = VEC_BASE + (VEC_W'(src_idx) * VEC_STEP);
            prio     = act_lvl;
        end else begin
            vec_code = '0;
            prio     = '0;
        end
    end

endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder
    import irl_pkg::*;
#(
    parameter int               LVL_W    = 4,
    parameter int               VEC_W    = 12,
    parameter logic [VEC_W-1:0] VEC_BASE = 12'h200,
    parameter logic [VEC_W-1:0] VEC_STEP = 12'h020
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LVL_W-1:0]          irl_in,
    input  logic                      grp_en,
    input  logic                      irq_ack,
    output logic [(1 << LVL_W)-2:0]   src_pending,
    output logic                      irq_req,
    output logic [VEC_W-1:0]          irq_vec,
    output logic [LVL_W-1:0]          irq_prio
);

    localparam int NUM_SRC = (1 << LVL_W) - 1;

    irl_state_e       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] act_q, act_d;
    logic             en_q;
    logic             lvl_ok;
    logic             active;

    irl_sync_filter #(
        .LVL_W (LVL_W)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (irl_in),
        .lvl_q   (lvl_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= grp_en;
        end
    end

    assign lvl_ok = en_q && (lvl_q != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lvl_ok) begin
                    state_d = ST_REQ;
                    act_d   = lvl_q;
                end
            end
            ST_REQ: begin
                if (!lvl_ok)             state_d = ST_IDLE;
                else if (lvl_q != act_q) state_d = ST_SWITCH;
                else if (irq_ack)        state_d = ST_SERVED;
            end
            ST_SERVED: begin
                if (!lvl_ok)             state_d = ST_IDLE;
                else if (lvl_q != act_q) state_d = ST_SWITCH;
            end
            ST_SWITCH: begin
                act_d   = lvl_q;
                state_d = lvl_ok ? ST_REQ : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        active  = en_q && ((state_q == ST_REQ) || (state_q == ST_SERVED));
        irq_req = active;
    end

    irl_source_decode #(
        .LVL_W    (LVL_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_decode (
        .valid    (active),
        .act_lvl  (act_q),
        .pending  (src_pending),
        .vec_code (irq_vec),
        .prio     (irq_prio)
    );

    // R5: the bundle never holds two pending sources
    assert_single_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_pending));

    // R3: vector code follows the reported priority
    assert_vec_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == VEC_BASE + (VEC_W'(irq_prio ^ {LVL_W{1'b1}}) * VEC_STEP)));

    // R4: an accepted zero level withdraws the request
    assert_zero_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == '0) |=> !irq_req);

    // R8: a disabled group raises nothing on the next cycle
    assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en |=> (!irq_req && (src_pending == '0)));

    // R9: acknowledge leaves a held level pending
    assert_ack_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && irq_ack && lvl_q == act_q && lvl_q != '0 && en_q && grp_en)
            |=> irq_req);

    // R10: vector and priority hold while the request stays up
    assert_stable_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> (!irq_req || ($stable(irq_vec) && $stable(irq_prio))));

endmodule

// File: tb/tb_irl_level_decoder.sv
module tb_irl_level_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irl_in = 4'd0;
    logic        grp_en = 1'b0;
    logic        irq_ack = 1'b0;
    logic [14:0] src_pending;
    logic        irq_req;
    logic [11:0] irq_vec;
    logic [3:0]  irq_prio;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irl_level_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irl_in      (irl_in),
        .grp_en      (grp_en),
        .irq_ack     (irq_ack),
        .src_pending (src_pending),
        .irq_req     (irq_req),
        .irq_vec     (irq_vec),
        .irq_prio    (irq_prio)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // expected outputs for a pending level (0 = none)
    task automatic expect_level(input string req, input int lvl);
        if (lvl == 0) begin
            chk({req, " req"}, int'(irq_req), 0);
            chk({req, " pending"}, int'(src_pending), 0);
            chk({req, " vec"}, int'(irq_vec), 0);
            chk({req, " prio"}, int'(irq_prio), 0);
        end else begin
            chk({req, " req"}, int'(irq_req), 1);
            chk({req, " pending"}, int'(src_pending), 1 << (lvl ^ 15));
            chk({req, " vec"}, int'(irq_vec), 'h200 + (lvl ^ 15) * 'h20);
            chk({req, " prio"}, int'(irq_prio), lvl);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cur;
        @(negedge clk);
        @(negedge clk);
        expect_level("R1 reset", 0);
        rst_n = 1'b1;
        edges(2);
        expect_level("R1 after reset", 0);

        // R8: disabled group ignores a present level
        irl_in = 4'd7;
        edges(8);
        expect_level("R8 disabled", 0);
        grp_en = 1'b1;
        edges(1);
        chk("R8 enable one edge", int'(irq_req), 0);
        edges(1);
        expect_level("R8 enable two edges", 7);
        grp_en = 1'b0;
        edges(1);
        expect_level("R8 disable one edge", 0);
        irl_in = 4'd3;
        edges(8);
        expect_level("R8 disabled new level", 0);
        grp_en = 1'b1;
        edges(2);
        expect_level("R8 tracked level", 3);

        // R4: level zero clears
        irl_in = 4'd0;
        edges(4);
        expect_level("R4 before latency", 3);
        edges(1);
        expect_level("R4 cleared", 0);

        // R2 R3 R7: every level from idle
        for (int l = 1; l < 16; l++) begin
            irl_in = 4'(l);
            edges(4);
            chk("R7 not yet", int'(irq_req), 0);
            edges(1);
            expect_level("R2 R3 sweep", l);
            irl_in = 4'd0;
            edges(6);
            expect_level("R4 sweep clear", 0);
        end

        // R5: every ordered pair of nonzero levels
        cur = 0;
        for (int a = 1; a < 16; a++) begin
            for (int b = 1; b < 16; b++) begin
                if (a != b) begin
                    if (cur != a) begin
                        irl_in = 4'(a);
                        edges(8);
                    end
                    irl_in = 4'(b);
                    edges(4);
                    expect_level("R5 old held", a);
                    edges(1);
                    expect_level("R5 gap", 0);
                    edges(1);
                    expect_level("R5 new source", b);
                    cur = b;
                end
            end
        end

        // R6: one-cycle glitch ignored
        irl_in = 4'd5;
        edges(8);
        expect_level("R6 base", 5);
        irl_in = 4'd9;
        edges(1);
        irl_in = 4'd5;
        for (int i = 0; i < 8; i++) begin
            edges(1);
            expect_level("R6 glitch ignored", 5);
        end
        // R6: two-cycle value accepted
        irl_in = 4'd9;
        edges(2);
        irl_in = 4'd5;
        edges(4);
        expect_level("R6 two-cycle accepted", 9);
        edges(6);
        expect_level("R6 restored", 5);

        // R9: acknowledge does not clear
        irq_ack = 1'b1;
        edges(1);
        irq_ack = 1'b0;
        expect_level("R9 at ack", 5);
        edges(5);
        expect_level("R9 after ack", 5);
        irl_in = 4'd12;
        edges(6);
        expect_level("R9 served then switch", 12);

        // R10: outputs steady during a long hold
        for (int i = 0; i < 10; i++) begin
            edges(1);
            expect_level("R10 hold", 12);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule